// File: doc/BRIEF.md
# Chainable 3x3 Convolution Engine

This block is a fixed-point multiply-accumulate engine that reduces a window of nine activations against nine weights and produces a new sum on every clock cycle. In two-dimensional mode all nine lanes take part, so one full 3x3 window is consumed per cycle. In one-dimensional mode a run-time tap count enables only the lowest lanes, which turns the engine into a short FIR filter of one to nine taps.

The engine has a cascade input and a cascade output. The cascade input is added in the last pipeline stage. A chain of up to eight engines therefore forms a single filter of up to 72 taps. In a chain, each engine takes its window one cycle after the engine upstream of it. A build-time parameter selects either a 16-bit fixed-point datapath or a binarized datapath. The binarized datapath uses one-bit weights and has two build-time encodings for its activations. The fixed-point datapath can also take its activations as signed bytes instead of full words, chosen at run time.

Top module: `conv3x3_engine`

## Requirements
- R1: In two-dimensional mode (`dimMode`=0), `result` equals the sum over all nine lanes of the signed activation times the signed weight, plus `casIn`, whatever `tapCount` holds. A new window is accepted on every cycle.
- R2: `outValid` rises exactly three clock edges after the edge that samples `inValid` high. One result leaves the engine for each accepted window.
- R3: In one-dimensional mode (`dimMode`=1), lane i (its bits at i*ACT_W) contributes only when i < `tapCount`. A tap count of 0 yields `casIn` alone, and counts of 9 to 15 enable all nine lanes.
- R4: With `actNarrow`=1, each activation lane is the signed value of its low byte, and its upper byte has no effect on `result`.
- R5: The `casIn` value used for a window is the one present during the cycle before that window's `outValid` goes high, which is two edges after the window is sampled. `casOut` carries the same value as `result`.
- R6: Eight engines chained from `casOut` to `casIn`, all held in one-dimensional mode with steady inputs, deliver at the last engine the sum of every enabled tap of all eight engines.
- R7: The 39-bit accumulator holds 72 products of -32768 by -32768, or of -32768 by 32767, without wrapping.
- R8: While no result is being delivered (`outValid`=0), `result` keeps its last value.
- R9: While `rstN` is low, `outValid` and `result` are 0, even if `inValid` is high.
- R10: In the binarized build with the plus/minus-one encoding, each enabled lane adds +1 when bit 0 of its activation equals bit 0 of its weight and -1 otherwise. No other bits have an effect.
- R11: In the binarized build with the plus-one/zero encoding, an enabled lane whose activation bit 0 is 0 adds nothing. Otherwise it adds +1 when weight bit 0 is 1 and -1 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | The window on the data inputs is to be processed |
| dimMode | input | 1 | 0: 3x3 window, 1: one-dimensional filter |
| tapCount | input | 4 | Number of enabled lanes in one-dimensional mode |
| actNarrow | input | 1 | 1: activations are signed low bytes |
| winAct | input | 9*ACT_W | Nine activation lanes, lane 0 in the low bits |
| winWgt | input | 9*WGT_W | Nine weight lanes, lane 0 in the low bits |
| casIn | input | ACC_W | Partial sum from the upstream engine |
| outValid | output | 1 | `result` holds a new sum |
| result | output | ACC_W | Accumulated signed sum |
| casOut | output | ACC_W | Partial sum for the downstream engine |

## Verification
The bound checker watches the engine on every cycle for four things. It checks the three-edge pairing between `inValid` and `outValid` in both directions. It checks that `result` is held while no result is delivered. It checks that a window with all weights zero, or with zero enabled taps, passes the aligned `casIn` through unchanged. The arithmetic itself can only be shown by the bench's streams, which compare every result with sums computed in the bench. Those streams cover back-to-back windows with the cascade value changing every cycle, the full sweep of tap counts, byte activations with junk in the upper byte, and all 512 binarized activation patterns. Only the bench's eight-engine chain with extreme operands can show the cascade skew and the guard bits.

// File: rtl/conv_pkg.sv
package conv_pkg;
  // Window is a square kernel; lane count follows from its side.
  localparam int KDIM  = 3;
  localparam int LANES = KDIM * KDIM;

  // Strobes from the control path into the arithmetic path.
  typedef struct packed {
    logic [LANES-1:0] laneEn;    // lanes allowed to contribute
    logic             narrowAct; // activations are signed bytes
    logic             capture;   // load product registers
    logic             reduce;    // load lane-sum register
    logic             commit;    // load result (adds cascade)
  } conv_strobe_t;
endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_pkg::*;
#(
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             dimMode,
  input  logic [TAP_W-1:0] tapCount,
  input  logic             actNarrow,
  output conv_strobe_t     strb,
  output logic             outValid
);
  logic [LANES-1:0] laneMask;
  logic             stg1Vld;
  logic             stg2Vld;
  logic             stg3Vld;

  // Lane i is live in 1D mode only below the tap count.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      laneMask[i] = !dimMode || (i < int'(tapCount));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg1Vld <= 1'b0;
      stg2Vld <= 1'b0;
      stg3Vld <= 1'b0;
    end else begin
      stg1Vld <= inValid;
      stg2Vld <= stg1Vld;
      stg3Vld <= stg2Vld;
    end
  end

  always_comb begin
    strb.laneEn    = laneMask;
    strb.narrowAct = actNarrow;
    strb.capture   = inValid;
    strb.reduce    = stg1Vld;
    strb.commit    = stg2Vld;
  end

  assign outValid = stg3Vld;
endmodule

// File: rtl/conv_datapath.sv
module conv_datapath
  import conv_pkg::*;
#(
  parameter int ACT_W    = 16,
  parameter int WGT_W    = 16,
  parameter int ACC_W    = 39,
  parameter int BNN_MODE = 0,
  parameter int BNN_PM1  = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  conv_strobe_t             strb,
  input  logic [LANES*ACT_W-1:0]   winAct,
  input  logic [LANES*WGT_W-1:0]   winWgt,
  input  logic signed [ACC_W-1:0]  casIn,
  output logic signed [ACC_W-1:0]  result
);
  localparam int PROD_W   = ACT_W + WGT_W;
  localparam int NARROW_W = ACT_W / 2;
  localparam logic signed [PROD_W-1:0] P_ONE = PROD_W'(1);
  localparam logic signed [PROD_W-1:0] P_NEG = -PROD_W'(1);

  logic signed [PROD_W-1:0] prodMasked [LANES];
  logic signed [PROD_W-1:0] prodQ      [LANES];
  logic signed [ACC_W-1:0]  laneSum;
  logic signed [ACC_W-1:0]  sumQ;
  logic signed [ACC_W-1:0]  resQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic signed [ACT_W-1:0]  aRaw;
    logic signed [WGT_W-1:0]  wRaw;
    logic signed [PROD_W-1:0] prod;
    assign aRaw = winAct[g*ACT_W +: ACT_W];
    assign wRaw = winWgt[g*WGT_W +: WGT_W];

    if (BNN_MODE == 0) begin : gFix
      logic signed [ACT_W-1:0] aSel;
      assign aSel = strb.narrowAct
                  ? {{(ACT_W-NARROW_W){aRaw[NARROW_W-1]}}, aRaw[NARROW_W-1:0]}
                  : aRaw;
      assign prod = PROD_W'(aSel) * PROD_W'(wRaw);
    end else if (BNN_PM1 != 0) begin : gPm
      // Sign agreement gives +1, disagreement -1.
      assign prod = (aRaw[0] ~^ wRaw[0]) ? P_ONE : P_NEG;
    end else begin : gPz
      // Zero activation drops out; one takes the weight's sign.
      assign prod = !aRaw[0] ? '0 : (wRaw[0] ? P_ONE : P_NEG);
    end

    assign prodMasked[g] = strb.laneEn[g] ? prod : '0;
  end

  // Stage 1: registered products.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) prodQ[i] <= '0;
    end else if (strb.capture) begin
      for (int i = 0; i < LANES; i++) prodQ[i] <= prodMasked[i];
    end
  end

  always_comb begin
    laneSum = '0;
    for (int i = 0; i < LANES; i++) laneSum = laneSum + ACC_W'(prodQ[i]);
  end

  // Stage 2: lane sum. Stage 3: cascade join.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ <= '0;
      resQ <= '0;
    end else begin
      if (strb.reduce) sumQ <= laneSum;
      if (strb.commit) resQ <= sumQ + casIn;
    end
  end

  assign result = resQ;
endmodule

// File: rtl/conv3x3_engine.sv
module conv3x3_engine
  import conv_pkg::*;
#(
  parameter int ACT_W     = 16,
  parameter int WGT_W     = 16,
  parameter int MAX_CHAIN = 8,
  parameter int BNN_MODE  = 0,
  parameter int BNN_PM1   = 1,
  localparam int GUARD_W  = $clog2(LANES * MAX_CHAIN),
  localparam int ACC_W    = ACT_W + WGT_W + GUARD_W,
  localparam int TAP_W    = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    dimMode,
  input  logic [TAP_W-1:0]        tapCount,
  input  logic                    actNarrow,
  input  logic [LANES*ACT_W-1:0]  winAct,
  input  logic [LANES*WGT_W-1:0]  winWgt,
  input  logic signed [ACC_W-1:0] casIn,
  output logic                    outValid,
  output logic signed [ACC_W-1:0] result,
  output logic signed [ACC_W-1:0] casOut
);
  conv_strobe_t strb;
  logic signed [ACC_W-1:0] resInt;

  conv_ctrl #(.TAP_W(TAP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dimMode(dimMode),
    .tapCount(tapCount), .actNarrow(actNarrow), .strb(strb),
    .outValid(outValid)
  );

  conv_datapath #(
    .ACT_W(ACT_W), .WGT_W(WGT_W), .ACC_W(ACC_W),
    .BNN_MODE(BNN_MODE), .BNN_PM1(BNN_PM1)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .winAct(winAct),
    .winWgt(winWgt), .casIn(casIn), .result(resInt)
  );

  assign result = resInt;
  assign casOut = resInt;
endmodule

// File: rtl/conv3x3_chk.sv
module conv3x3_chk #(
  parameter int LANES    = 9,
  parameter int WGT_W    = 16,
  parameter int ACC_W    = 39,
  parameter int TAP_W    = 4,
  parameter int BNN_MODE = 0
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    dimMode,
  input logic [TAP_W-1:0]        tapCount,
  input logic [LANES*WGT_W-1:0]  winWgt,
  input logic signed [ACC_W-1:0] casIn,
  input logic                    outValid,
  input logic signed [ACC_W-1:0] result
);
  // Edges since reset, saturating; history is trusted once it reaches 3.
  logic [1:0] sinceRst;
  logic       warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end
  assign warm = (sinceRst == 2'd3);

  // R2
  lat_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(inValid, 3)) |-> outValid);

  // R2
  lat_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid) |-> $past(inValid, 3));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(result));

  // R3
  no_tap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(inValid && dimMode && (tapCount == '0), 3))
      |-> (result == $past(casIn)));

  if (BNN_MODE == 0) begin : gFixChk
    // R5
    zero_wgt_chk: assert property (@(posedge clk) disable iff (!rstN)
      (warm && $past(inValid && (winWgt == '0), 3))
        |-> (result == $past(casIn)));
  end
endmodule

bind conv3x3_engine conv3x3_chk #(
  .LANES(LANES), .WGT_W(WGT_W), .ACC_W(ACC_W), .TAP_W(TAP_W),
  .BNN_MODE(BNN_MODE)
) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .dimMode(dimMode),
  .tapCount(tapCount), .winWgt(winWgt), .casIn(casIn),
  .outValid(outValid), .result(result)
);

// File: tb/sim_conv3x3_engine.sv
module sim_conv3x3_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 9;
  localparam int AW   = 16;
  localparam int BACC = 39;
  localparam int MAXV = 520;
  localparam int NCH  = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN = 1'b0;
  logic inValid = 1'b0, dimMode = 1'b0, actNarrow = 1'b0;
  logic [3:0] tapCount = '0;
  logic [NL*AW-1:0] winAct = '0, winWgt = '0;
  logic signed [BACC-1:0] casIn = '0;
  logic ovC, ovP, ovZ;
  logic signed [BACC-1:0] resC, resP, resZ, coC, coP, coZ;

  conv3x3_engine u0 (.clk(clk), .rstN(rstN), .inValid(inValid), .dimMode(dimMode),
    .tapCount(tapCount), .actNarrow(actNarrow), .winAct(winAct), .winWgt(winWgt),
    .casIn(casIn), .outValid(ovC), .result(resC), .casOut(coC));
  conv3x3_engine #(.BNN_MODE(1), .BNN_PM1(1)) uPm (.clk(clk), .rstN(rstN),
    .inValid(inValid), .dimMode(dimMode), .tapCount(tapCount), .actNarrow(actNarrow),
    .winAct(winAct), .winWgt(winWgt), .casIn(casIn), .outValid(ovP), .result(resP),
    .casOut(coP));
  conv3x3_engine #(.BNN_MODE(1), .BNN_PM1(0)) uPz (.clk(clk), .rstN(rstN),
    .inValid(inValid), .dimMode(dimMode), .tapCount(tapCount), .actNarrow(actNarrow),
    .winAct(winAct), .winWgt(winWgt), .casIn(casIn), .outValid(ovZ), .result(resZ),
    .casOut(coZ));

  // Eight-engine chain for long filters.
  logic [NL*AW-1:0] chAct [NCH];
  logic [NL*AW-1:0] chWgt [NCH];
  logic [3:0] chTap = 4'd9;
  logic chVal = 1'b0;
  logic signed [BACC-1:0] chRes [NCH];
  logic signed [BACC-1:0] chCas [NCH];
  logic signed [BACC-1:0] chRpt [NCH];
  logic chOv [NCH];
  for (genvar e = 0; e < NCH; e++) begin : gCh
    if (e == 0) begin : gHead
      assign chCas[e] = '0;
    end else begin : gLink
      assign chCas[e] = chRes[e-1];
    end
    conv3x3_engine uE (.clk(clk), .rstN(rstN), .inValid(chVal), .dimMode(1'b1),
      .tapCount(chTap), .actNarrow(1'b0), .winAct(chAct[e]), .winWgt(chWgt[e]),
      .casIn(chCas[e]), .outValid(chOv[e]), .result(chRes[e]), .casOut(chRpt[e]));
  end

  // Stimulus store.
  logic [AW-1:0] sAct [MAXV][NL];
  logic [AW-1:0] sWgt [MAXV][NL];
  logic sDim [MAXV];
  logic sNar [MAXV];
  logic sVal [MAXV];
  logic [3:0] sTap [MAXV];
  longint sCas [MAXV];

  int nChk = 0, nFail = 0;
  bit done = 1'b0;
  longint holdC = 0, holdP = 0, holdZ = 0;

  task automatic chk(input string req, input longint got, input longint exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic bit laneOn(input int k, input int i);
    return !sDim[k] || (i < int'(sTap[k]));
  endfunction

  function automatic longint expFix(input int k);
    longint s = sCas[k];
    for (int i = 0; i < NL; i++) begin
      longint a, w;
      a = sNar[k] ? longint'($signed(sAct[k][i][7:0])) : longint'($signed(sAct[k][i]));
      w = longint'($signed(sWgt[k][i]));
      if (laneOn(k, i)) s += a * w;
    end
    return s;
  endfunction

  function automatic longint expBin(input int k, input bit pm);
    longint s = sCas[k];
    for (int i = 0; i < NL; i++) begin
      if (laneOn(k, i)) begin
        if (pm) s += (sAct[k][i][0] == sWgt[k][i][0]) ? 1 : -1;
        else if (sAct[k][i][0]) s += sWgt[k][i][0] ? 1 : -1;
      end
    end
    return s;
  endfunction

  // Stream n stored windows back to back; cascade value follows two edges later.
  task automatic runStream(input int n, input string tag);
    for (int j = 0; j < n + 3; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        int k = j - 3;
        chk(tag, longint'(ovC), longint'(sVal[k]));
        if (sVal[k]) begin
          holdC = expFix(k); holdP = expBin(k, 1'b1); holdZ = expBin(k, 1'b0);
        end
        chk(tag, longint'(resC), holdC);
        chk("R5", longint'(coC), holdC);
        chk("R10", longint'(resP), holdP);
        chk("R11", longint'(resZ), holdZ);
      end
      if (j < n) begin
        inValid = sVal[j]; dimMode = sDim[j]; actNarrow = sNar[j]; tapCount = sTap[j];
        for (int i = 0; i < NL; i++) begin
          winAct[i*AW +: AW] = sAct[j][i];
          winWgt[i*AW +: AW] = sWgt[j][i];
        end
      end else begin
        inValid = 1'b0;
      end
      casIn = (j >= 2 && j - 2 < n) ? BACC'(sCas[j-2]) : '0;
    end
  endtask

  task automatic fillRand(input int k, input bit dim, input bit nar, input bit val,
                          input logic [3:0] tap, input longint cas);
    for (int i = 0; i < NL; i++) begin
      sAct[k][i] = 16'($urandom);
      sWgt[k][i] = 16'($urandom);
    end
    sDim[k] = dim; sNar[k] = nar; sVal[k] = val; sTap[k] = tap; sCas[k] = cas;
  endtask

  function automatic longint smallCas();
    return longint'($signed(21'($urandom)));
  endfunction

  task automatic doReset(input string tag);
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b1;
    repeat (2) @(negedge clk);
    chk(tag, longint'(ovC), 0);
    chk(tag, longint'(resC), 0);
    chk(tag, longint'(resP), 0);
    chk(tag, longint'(resZ), 0);
    chk(tag, longint'(chRes[NCH-1]), 0);
    inValid = 1'b0;
    rstN = 1'b1;
    holdC = 0; holdP = 0; holdZ = 0;
  endtask

  task automatic runChain(input string tag, input logic [3:0] tap, input int kind);
    longint expS = 0;
    @(negedge clk);
    chTap = tap; chVal = 1'b1;
    for (int e = 0; e < NCH; e++) begin
      for (int i = 0; i < NL; i++) begin
        logic [AW-1:0] a, w;
        a = (kind == 2) ? 16'($urandom) : 16'h8000;
        w = (kind == 2) ? 16'($urandom) : ((kind == 0) ? 16'h8000 : 16'h7fff);
        chAct[e][i*AW +: AW] = a;
        chWgt[e][i*AW +: AW] = w;
        if (i < int'(tap)) expS += longint'($signed(a)) * longint'($signed(w));
      end
    end
    repeat (3 * NCH + 6) @(negedge clk);
    chk(tag, longint'(chOv[NCH-1]), 1);
    chk(tag, longint'(chRes[NCH-1]), expS);
    chk(tag, longint'(chRpt[NCH-1]), expS);
    chVal = 1'b0;
  endtask

  initial begin
    for (int e = 0; e < NCH; e++) begin chAct[e] = '0; chWgt[e] = '0; end
    // R9: reset state, with inValid high during reset
    doReset("R9");

    // R1: 2D windows back to back, tap count random and ignored
    for (int k = 0; k < 40; k++) fillRand(k, 1'b0, 1'b0, 1'b1, 4'($urandom), smallCas());
    runStream(40, "R1");

    // R2: 2D extremes; latency pairing checked through outValid
    for (int k = 0; k < 4; k++) begin
      fillRand(k, 1'b0, 1'b0, 1'b1, 4'd0, 0);
      for (int i = 0; i < NL; i++) begin
        sAct[k][i] = (k[0]) ? 16'h7fff : 16'h8000;
        sWgt[k][i] = (k[1]) ? 16'h7fff : 16'h8000;
      end
    end
    runStream(4, "R2");

    // R3: every tap count value in 1D mode
    for (int k = 0; k < 64; k++) fillRand(k, 1'b1, 1'b0, 1'b1, 4'(k % 16), smallCas());
    runStream(64, "R3");

    // R4: byte activations with junk upper bytes, both dimensions
    for (int k = 0; k < 40; k++) fillRand(k, k[0], 1'b1, 1'b1, 4'(k % 10), smallCas());
    runStream(40, "R4");

    // R8: gaps in the valid stream must leave the result untouched
    for (int k = 0; k < 40; k++) fillRand(k, 1'b0, 1'b0, ($urandom % 3) == 0, 4'd9, smallCas());
    runStream(40, "R8");

    // R5: large cascade values, zero and nonzero weights
    for (int k = 0; k < 16; k++) begin
      fillRand(k, 1'b0, 1'b0, 1'b1, 4'd9,
               (k[0] ? -1 : 1) * (longint'(1) <<< 36) + longint'(k));
      if (k[1]) for (int i = 0; i < NL; i++) sWgt[k][i] = '0;
    end
    runStream(16, "R5");

    // R10, R11: all 512 binary activation patterns, varied weights
    for (int k = 0; k < 512; k++) begin
      fillRand(k, 1'b0, 1'b0, 1'b1, 4'd9, smallCas());
      for (int i = 0; i < NL; i++) begin
        sAct[k][i][0] = k[i];
        sWgt[k][i][0] = ((k * 37 + 5) >> i) & 1;
      end
    end
    runStream(512, "R1");

    // R9: reset in the middle of operation
    doReset("R9");

    // R7: worst-case magnitudes over 72 taps
    runChain("R7", 4'd9, 0);
    runChain("R7", 4'd9, 1);
    // R6: random chained filters, full and partial tap counts
    runChain("R6", 4'd9, 2);
    runChain("R6", 4'd5, 2);
    runChain("R6", 4'd1, 2);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      nChk++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule